// File: doc/BRIEF.md
# Unequal-Latency Issue Interlock

This block decides, every cycle, whether the instruction held in the decode stage of an in-order pipeline may move on. It serves two execution paths that lead into one memory stage. The integer path takes one execute cycle. The floating-point add path takes four pipelined execute stages. Both paths then pass through a memory stage that holds one instruction per cycle. Stores use the integer path. A store reads its base register when it enters execute and its data register when it enters the memory stage.

For each architectural register the block keeps a countdown of the cycles until a pending result can be forwarded. It also keeps a shift register of memory-stage slots already claimed by instructions in flight. Decode presents the instruction's class, two source registers and a destination. The block answers with a hold request and a flag that says whether the hold is structural. A held instruction stays in decode while older instructions keep advancing, and no bubble claims a memory slot.

Top module: `issue_interlock`

## Requirements
- R1: After reset no register is pending and no memory slot is claimed. The first instruction after reset issues without a hold, even if it reads the destination of an add that issued before the reset.
- R2: An instruction that reads the result of an integer-class instruction that issued in the previous cycle issues without a hold. This applies to an operand read and to a store's data read.
- R3: An integer or add instruction that reads the destination of an add that issued in the previous cycle is held for three cycles with `issueStall`=1 and `structStall`=0, then issues.
- R4: A store whose data register (source B) is the destination of an add that issued in the previous cycle is held for two data-hazard cycles (`structStall`=0), then one structural cycle (`structStall`=1), then issues.
- R5: A store's base register (source A) is needed at execute entry. A store whose base is the destination of an add that issued in the previous cycle is held three cycles with `structStall`=0.
- R6: An instruction whose memory-stage cycle would coincide with one already claimed takes a structural hold. An independent integer instruction in decode three cycles after an add issues (with two integer instructions issued in between) is held one cycle with `structStall`=1.
- R7: When a data hazard and a memory-slot conflict apply in the same cycle, the hold is reported as a data hazard (`issueStall`=1, `structStall`=0).
- R8: With `idValid`=0 there is no hold, and the presented destination is neither marked pending nor given a memory slot.
- R9: When a register already pending is written again, it stays pending for the longer of its remaining time and the new latency. An integer write that follows an add to the same register does not shorten the wait.
- R10: Add instructions never take a structural hold. Back-to-back independent adds all issue without a hold.
- R11: Class encoding of `idUnit`: 0 = integer (one execute cycle, writes its destination), 1 = floating-point add (four execute stages, writes its destination), 2 = store (integer path, writes no register), 3 = treated as integer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idValid | input | 1 | Decode stage holds an instruction |
| idUnit | input | 2 | Instruction class (encoding in R11) |
| idSrcA | input | 5 | Source A: operand, or the store's base |
| idSrcB | input | 5 | Source B: operand, or the store's data |
| idDest | input | 5 | Destination register (ignored for stores) |
| issueStall | output | 1 | Hold the decode-stage instruction this cycle |
| structStall | output | 1 | The hold is caused only by the memory-stage slot |

## Verification
The bench targets the edges of each wait. It checks the cycle on which a dependent of an add is released, and checks that a store's data register is released one cycle earlier than its base. A design that read store data at execute entry would add a third data-hazard cycle and lose the structural cycle of R4. It also builds the case where a data hazard and a memory conflict overlap, which a design with the wrong priority would mislabel. It builds the overwrite case, where a design that just reloads the counter would release the add's consumer two cycles too early. Bubbles that carry a pending-looking destination check that an idle slot reserves nothing. A seeded random stream over a small register pool is compared with a cycle-indexed model kept in the bench.

// File: rtl/iss_pkg.sv
package iss_pkg;

  typedef enum logic [1:0] {
    UNIT_INT   = 2'd0,
    UNIT_FADD  = 2'd1,
    UNIT_STORE = 2'd2,
    UNIT_RSVD  = 2'd3
  } unit_e;

  // Strobes sent from control to the scoreboard datapath.
  typedef struct packed {
    logic fire;     // decode instruction leaves this cycle
    logic wrDest;   // it writes its destination register
    logic longLat;  // it takes the multi-stage add path
  } issueStrb_t;

endpackage

// File: rtl/iss_scoreboard.sv
module iss_scoreboard
  import iss_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int INT_LAT  = 1,
  parameter int FADD_LAT = 4,
  localparam int RW = $clog2(NUM_REGS),
  localparam int CW = $clog2(FADD_LAT + 1),
  localparam int OW = FADD_LAT + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  issueStrb_t    strb,
  input  logic [RW-1:0] dest,
  input  logic [RW-1:0] srcA,
  input  logic [RW-1:0] srcB,
  output logic [CW-1:0] cntA,
  output logic [CW-1:0] cntB,
  output logic [OW-1:0] occ
);

  localparam logic [CW-1:0] INT_CNT  = CW'(INT_LAT);
  localparam logic [CW-1:0] FADD_CNT = CW'(FADD_LAT);

  logic [CW-1:0] latSel;
  logic [CW-1:0] pendFlat [NUM_REGS];
  logic [OW-1:0] occNxt;

  assign latSel = strb.longLat ? FADD_CNT : INT_CNT;

  // Per-register countdown of cycles until the result can be forwarded.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [CW-1:0] cnt;
    logic [CW-1:0] dec;
    logic          hit;

    assign dec = (cnt != '0) ? cnt - 1'b1 : '0;
    assign hit = strb.fire && strb.wrDest && (dest == RW'(g));

    always_ff @(posedge clk) begin
      if (!rstN)    cnt <= '0;
      else if (hit) cnt <= (dec > latSel) ? dec : latSel;
      else          cnt <= dec;
    end

    assign pendFlat[g] = cnt;
  end

  assign cntA = pendFlat[srcA];
  assign cntB = pendFlat[srcB];

  // occ[i] set: memory stage already claimed i+1 cycles from now.
  always_comb begin
    occNxt = {1'b0, occ[OW-1:1]};
    if (strb.fire) begin
      if (strb.longLat) occNxt[FADD_LAT-1] = 1'b1;
      else              occNxt[INT_LAT-1]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) occ <= '0;
    else       occ <= occNxt;
  end

endmodule

// File: rtl/iss_control.sv
module iss_control
  import iss_pkg::*;
#(
  parameter int INT_LAT  = 1,
  parameter int FADD_LAT = 4,
  localparam int CW = $clog2(FADD_LAT + 1),
  localparam int OW = FADD_LAT + 1
) (
  input  logic          idValid,
  input  logic [1:0]    idUnit,
  input  logic [CW-1:0] cntA,
  input  logic [CW-1:0] cntB,
  input  logic [OW-1:0] occ,
  output issueStrb_t    strb,
  output logic          issueStall,
  output logic          structStall
);

  // A countdown at or below these limits can be forwarded in time.
  localparam int EX_READY = 1;
  localparam int MEM_GAP  = 1;
  localparam logic [CW-1:0] EX_LIM  = CW'(EX_READY);
  localparam logic [CW-1:0] MEM_LIM = CW'(EX_READY + MEM_GAP);

  logic isStore, isFadd, rawHaz, memHaz;

  assign isStore = (idUnit == UNIT_STORE);
  assign isFadd  = (idUnit == UNIT_FADD);

  assign rawHaz = idValid &&
                  ((cntA > EX_LIM) || (cntB > (isStore ? MEM_LIM : EX_LIM)));
  assign memHaz = idValid && (isFadd ? occ[FADD_LAT] : occ[INT_LAT]);

  assign issueStall  = rawHaz || memHaz;
  assign structStall = memHaz && !rawHaz;

  assign strb.fire    = idValid && !issueStall;
  assign strb.wrDest  = !isStore;
  assign strb.longLat = isFadd;

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import iss_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int INT_LAT  = 1,
  parameter int FADD_LAT = 4,
  localparam int RW = $clog2(NUM_REGS),
  localparam int CW = $clog2(FADD_LAT + 1),
  localparam int OW = FADD_LAT + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          idValid,
  input  logic [1:0]    idUnit,
  input  logic [RW-1:0] idSrcA,
  input  logic [RW-1:0] idSrcB,
  input  logic [RW-1:0] idDest,
  output logic          issueStall,
  output logic          structStall
);

  issueStrb_t    strb;
  logic [CW-1:0] cntA, cntB;
  logic [OW-1:0] occ;

  iss_control #(.INT_LAT(INT_LAT), .FADD_LAT(FADD_LAT)) u_ctl (
    .idValid(idValid), .idUnit(idUnit), .cntA(cntA), .cntB(cntB), .occ(occ),
    .strb(strb), .issueStall(issueStall), .structStall(structStall)
  );

  iss_scoreboard #(.NUM_REGS(NUM_REGS), .INT_LAT(INT_LAT), .FADD_LAT(FADD_LAT)) u_sb (
    .clk(clk), .rstN(rstN), .strb(strb), .dest(idDest),
    .srcA(idSrcA), .srcB(idSrcB), .cntA(cntA), .cntB(cntB), .occ(occ)
  );

endmodule

// File: rtl/iss_checker.sv
module iss_checker
  import iss_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int RW = $clog2(NUM_REGS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          idValid,
  input logic [1:0]    idUnit,
  input logic [RW-1:0] idSrcA,
  input logic [RW-1:0] idSrcB,
  input logic [RW-1:0] idDest,
  input logic          issueStall,
  input logic          structStall
);

  p_idle_no_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |-> (!issueStall && !structStall));

  p_add_no_struct_r10: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && idUnit == UNIT_FADD) |-> !structStall);

  p_add_dependent_waits_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(idValid && !issueStall && idUnit == UNIT_FADD) &&
     idValid && idSrcA == $past(idDest)) |-> (issueStall && !structStall));

  p_store_data_waits_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(idValid && !issueStall && idUnit == UNIT_FADD) &&
     idValid && idUnit == UNIT_STORE && idSrcB == $past(idDest))
    |-> (issueStall && !structStall));

endmodule

bind issue_interlock iss_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .idValid(idValid), .idUnit(idUnit),
  .idSrcA(idSrcA), .idSrcB(idSrcB), .idDest(idDest),
  .issueStall(issueStall), .structStall(structStall)
);

// File: tb/tb_issue_interlock.sv
`timescale 1ns/1ps
module tb_issue_interlock;

  localparam int CLK_NS = 20;
  localparam logic [1:0] U_INT = 2'd0, U_FADD = 2'd1, U_ST = 2'd2;

  logic clk = 1'b0, rstN = 1'b0, idValid = 1'b0;
  logic [1:0] idUnit = '0;
  logic [4:0] idSrcA = '0, idSrcB = '0, idDest = '0;
  logic issueStall, structStall;

  int compared = 0, mismatched = 0;
  int readyCyc [32];
  bit busy [64];
  int now = 0;
  bit lastHeld = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  issue_interlock dut (
    .clk(clk), .rstN(rstN), .idValid(idValid), .idUnit(idUnit),
    .idSrcA(idSrcA), .idSrcB(idSrcB), .idDest(idDest),
    .issueStall(issueStall), .structStall(structStall)
  );

  function automatic int latOf(input logic [1:0] u);
    return (u == U_FADD) ? 4 : 1;
  endfunction

  // Model: a result is usable by an execute-entry read from readyCyc on,
  // and by a store-data read one cycle earlier.
  function automatic bit modelRaw(input logic v, input logic [1:0] u,
                                  input logic [4:0] a, input logic [4:0] b);
    bit aWait, bWait;
    aWait = now < readyCyc[a];
    bWait = (u == U_ST) ? (now < readyCyc[b] - 1) : (now < readyCyc[b]);
    return v && (aWait || bWait);
  endfunction

  function automatic bit modelMem(input logic v, input logic [1:0] u);
    return v && busy[(now + latOf(u) + 1) % 64];
  endfunction

  task automatic clearModel();
    foreach (readyCyc[i]) readyCyc[i] = 0;
    foreach (busy[i]) busy[i] = 1'b0;
  endtask

  task automatic compare(input string tag, input int act, input int exp,
                         input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
               tag, what, act, exp, now);
    end
  endtask

  // One decode cycle. dIss/dStr < 0 means no hand-computed expectation.
  task automatic step(input logic v, input logic [1:0] u, input logic [4:0] a,
                      input logic [4:0] b, input logic [4:0] d,
                      input string tag, input int dIss, input int dStr);
    bit raw, mem, eIss, eStr;
    @(negedge clk);
    idValid = v; idUnit = u; idSrcA = a; idSrcB = b; idDest = d;
    #1;
    raw = modelRaw(v, u, a, b);
    mem = modelMem(v, u);
    eIss = raw || mem;
    eStr = mem && !raw;
    compare(tag, int'(issueStall), int'(eIss), "issueStall(model)");
    compare(tag, int'(structStall), int'(eStr), "structStall(model)");
    if (dIss >= 0) compare(tag, int'(issueStall), dIss, "issueStall");
    if (dStr >= 0) compare(tag, int'(structStall), dStr, "structStall");
    if (v && !eIss) begin
      busy[(now + latOf(u) + 1) % 64] = 1'b1;
      if (u != U_ST && readyCyc[d] < now + latOf(u)) readyCyc[d] = now + latOf(u);
    end
    lastHeld = eIss;
    busy[now % 64] = 1'b0;
    now++;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(1'b0, U_INT, 5'd0, 5'd0, 5'd0, "R8", 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    idValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    clearModel();
  endtask

  initial begin : watchdog
    #(CLK_NS * 200000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    clearModel();
    doReset();

    // R1: clean state after reset
    step(1, U_INT, 5'd1, 5'd2, 5'd3, "R1", 0, 0);

    // R2: integer forwarding, operand and store data
    drain();
    step(1, U_INT, 5'd1, 5'd2, 5'd5, "R2", 0, 0);
    step(1, U_INT, 5'd5, 5'd5, 5'd6, "R2", 0, 0);
    step(1, U_ST,  5'd5, 5'd6, 5'd0, "R2", 0, 0);

    // R3: add result consumed at execute entry
    drain();
    step(1, U_FADD, 5'd1, 5'd2, 5'd10, "R3", 0, 0);
    for (int i = 0; i < 3; i++) step(1, U_INT, 5'd10, 5'd1, 5'd11, "R3", 1, 0);
    step(1, U_INT, 5'd10, 5'd1, 5'd11, "R3", 0, 0);

    // R4: store data after add: 2 data cycles then 1 structural
    drain();
    step(1, U_FADD, 5'd1, 5'd2, 5'd12, "R4", 0, 0);
    step(1, U_ST, 5'd1, 5'd12, 5'd0, "R4", 1, 0);
    step(1, U_ST, 5'd1, 5'd12, 5'd0, "R4", 1, 0);
    step(1, U_ST, 5'd1, 5'd12, 5'd0, "R4", 1, 1);
    step(1, U_ST, 5'd1, 5'd12, 5'd0, "R4", 0, 0);

    // R5: store base after add
    drain();
    step(1, U_FADD, 5'd1, 5'd2, 5'd13, "R5", 0, 0);
    for (int i = 0; i < 3; i++) step(1, U_ST, 5'd13, 5'd1, 5'd0, "R5", 1, 0);
    step(1, U_ST, 5'd13, 5'd1, 5'd0, "R5", 0, 0);

    // R6: memory-slot collision of an independent integer instruction
    drain();
    step(1, U_FADD, 5'd1, 5'd2, 5'd14, "R6", 0, 0);
    step(1, U_INT, 5'd1, 5'd2, 5'd15, "R6", 0, 0);
    step(1, U_INT, 5'd1, 5'd2, 5'd16, "R6", 0, 0);
    step(1, U_INT, 5'd1, 5'd2, 5'd17, "R6", 1, 1);
    step(1, U_INT, 5'd1, 5'd2, 5'd17, "R6", 0, 0);

    // R7: both causes in one cycle: reported as data hazard
    drain();
    step(1, U_FADD, 5'd1, 5'd2, 5'd18, "R7", 0, 0);
    step(1, U_INT, 5'd1, 5'd2, 5'd19, "R7", 0, 0);
    step(1, U_INT, 5'd1, 5'd2, 5'd20, "R7", 0, 0);
    step(1, U_INT, 5'd18, 5'd1, 5'd21, "R7", 1, 0);
    step(1, U_INT, 5'd18, 5'd1, 5'd21, "R7", 0, 0);

    // R8: bubbles reserve nothing and never hold
    drain();
    step(0, U_FADD, 5'd1, 5'd2, 5'd22, "R8", 0, 0);
    step(1, U_INT, 5'd22, 5'd22, 5'd23, "R8", 0, 0);
    step(1, U_FADD, 5'd1, 5'd2, 5'd24, "R8", 0, 0);
    step(0, U_INT, 5'd24, 5'd24, 5'd0, "R8", 0, 0);

    // R9: later short write does not shorten a pending add
    drain();
    step(1, U_FADD, 5'd1, 5'd2, 5'd25, "R9", 0, 0);
    step(1, U_INT, 5'd1, 5'd2, 5'd25, "R9", 0, 0);
    step(1, U_INT, 5'd25, 5'd1, 5'd26, "R9", 1, 0);
    step(1, U_INT, 5'd25, 5'd1, 5'd26, "R9", 1, 0);
    step(1, U_INT, 5'd25, 5'd1, 5'd26, "R9", 0, 0);

    // R10 / R11: back-to-back adds, class 3 treated as integer
    drain();
    for (int i = 0; i < 4; i++)
      step(1, U_FADD, 5'd1, 5'd2, 5'(27 + i), "R10", 0, 0);
    drain();
    step(1, U_FADD, 5'd1, 5'd2, 5'd7, "R11", 0, 0);
    step(1, 2'd3, 5'd7, 5'd1, 5'd8, "R11", 1, 0);

    // R1: pending state is cleared by reset
    drain();
    step(1, U_FADD, 5'd1, 5'd2, 5'd31, "R1", 0, 0);
    doReset();
    step(1, U_INT, 5'd31, 5'd31, 5'd3, "R1", 0, 0);

    // Random stream over a small register pool; a held instruction stays.
    begin
      logic v; logic [1:0] u; logic [4:0] a, b, d;
      v = 1'b0; u = U_INT; a = '0; b = '0; d = '0;
      for (int i = 0; i < 3000; i++) begin
        if (!lastHeld) begin
          v = ($urandom % 100) < 85;
          u = 2'($urandom % 3);
          a = 5'($urandom % 8);
          b = 5'($urandom % 8);
          d = 5'($urandom % 8);
        end
        step(v, u, a, b, d, "RND", -1, -1);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule